// File: doc/BRIEF.md
# Descriptor Chain Engine

The engine runs several independent channels. Each channel walks a linked list of command descriptors stored in host memory. A channel starts when the host gives it the address of the first descriptor. For each descriptor the channel reads the descriptor from memory and passes its command to a shared command executor. When the executor finishes, the channel writes a completion word back into the descriptor. If the descriptor asks for an interrupt, the channel then raises one. It then follows the descriptor's link. A zero link ends the chain and the channel goes idle. The host never polls a status register, because the result of each descriptor lands in memory.

A descriptor is four 32-bit words at consecutive byte offsets from its base address:

| Offset | Content |
|---|---|
| +0 | Link to the next descriptor |
| +4 | Command |
| +8 | Interrupt-enable flag in bit 0 |
| +12 | Status, written by the engine |

All channels share one word-wide memory request port and one executor. Each is arbitrated round-robin. A grant lasts for exactly one transaction. Each channel has only one descriptor in flight at a time.

Top module: `desc_chain_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_req` and `exe_req` are all zero.
- R2: A start on an idle channel with a non-zero head makes it busy. It then issues read transactions (`mem_we`=0) at head+0 (link), head+4 (command) and head+8 (interrupt enable), in that order.
- R3: After the three reads, the channel requests the executor. `exe_cmd` carries the command word and `exe_chan` carries the channel number until `exe_done`.
- R4: After `exe_done`, the channel writes one word at descriptor base+12 with `mem_we`=1. The word is `exe_status` with bit 31 forced to 1.
- R5: When bit 0 of the interrupt-enable word is 1, `irq[c]` rises in the cycle after the status write is acknowledged. When that bit is 0, `irq[c]` does not rise.
- R6: A non-zero link makes the channel fetch the next descriptor at that address. A zero link returns the channel to idle (`busy[c]`=0) after the status write.
- R7: A start on a busy channel is ignored. A start with a zero head is also ignored.
- R8: Channels waiting for memory are served round-robin, starting from channel 0 after reset. `mem_req`, `mem_addr`, `mem_we` and `mem_chan` stay stable until `mem_ack`.
- R9: The executor serves one channel at a time, round-robin. `exe_req`, `exe_chan` and `exe_cmd` stay stable until `exe_done`.
- R10: `irq[c]` stays set until the host pulses `irq_clr[c]`. The pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | NCH | Per-channel start pulse |
| start_ptr | input | NCH*AW | Per-channel head address, channel c in bits [c*AW +: AW] |
| busy | output | NCH | Channel is working through a chain |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_chan | output | log2(NCH) | Channel owning the transaction |
| mem_ack | input | 1 | Transaction completes in this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| exe_req | output | 1 | Command handed to the executor |
| exe_cmd | output | 32 | Command word |
| exe_chan | output | log2(NCH) | Channel owning the executor |
| exe_done | input | 1 | Executor finished the command |
| exe_status | input | 32 | Result of the command, valid with `exe_done` |
| irq_clr | input | NCH | Per-channel interrupt clear |
| irq | output | NCH | Sticky per-channel interrupt flags |

## Verification
The hardest situation to reach is full contention. All four channels ask for the memory port in the same cycle, and later they queue for the executor while other channels are still fetching. Only then does the rotation of both arbiters show. The bench pulses all four start inputs in a single cycle right after reset. It records which channel owns each acknowledged memory transaction and each completed command, and it compares those orders with the round-robin rotation. Starting a channel again while it is still busy is reached by starting a three-descriptor chain with acknowledgements delayed by two cycles.

// File: rtl/desc_chain_engine.sv
module desc_chain_engine #(
  parameter int NCH = 4,
  parameter int AW  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           start_vld,
  input  logic [NCH*AW-1:0]        start_ptr,
  output logic [NCH-1:0]           busy,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [31:0]              mem_wdata,
  output logic [$clog2(NCH)-1:0]   mem_chan,
  input  logic                     mem_ack,
  input  logic [31:0]              mem_rdata,
  output logic                     exe_req,
  output logic [31:0]              exe_cmd,
  output logic [$clog2(NCH)-1:0]   exe_chan,
  input  logic                     exe_done,
  input  logic [31:0]              exe_status,
  input  logic [NCH-1:0]           irq_clr,
  output logic [NCH-1:0]           irq
);
  localparam int CW = $clog2(NCH);

  typedef enum logic [2:0] {S_IDLE, S_NXT, S_CMD, S_IEN, S_EXE, S_STS} st_t;

  st_t           st  [NCH];
  logic [AW-1:0] ptr [NCH];
  logic [AW-1:0] nxt [NCH];
  logic [31:0]   cmd [NCH];
  logic [31:0]   sts [NCH];
  logic          ien [NCH];

  logic          mem_busy, exe_busy;
  logic [CW-1:0] mem_own, mem_rr, exe_own, exe_rr;
  logic [NCH-1:0] mem_want, exe_want;
  logic [3:0]    off;
  logic          mem_acc, exe_fin;

  function automatic logic [CW-1:0] rr_pick(input logic [NCH-1:0] want, input logic [CW-1:0] base);
    logic [CW-1:0] pick;
    pick = base;
    for (int i = NCH-1; i >= 0; i--)
      if (want[(int'(base) + i) % NCH]) pick = CW'((int'(base) + i) % NCH);
    return pick;
  endfunction

  function automatic logic [CW-1:0] rr_next(input logic [CW-1:0] cur);
    return (int'(cur) == NCH-1) ? '0 : cur + 1'b1;
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      mem_want[c] = (st[c] == S_NXT) || (st[c] == S_CMD) || (st[c] == S_IEN) || (st[c] == S_STS);
      exe_want[c] = (st[c] == S_EXE);
      busy[c]     = (st[c] != S_IDLE);
    end
  end

  always_comb begin
    case (st[mem_own])
      S_CMD:   off = 4'd4;
      S_IEN:   off = 4'd8;
      S_STS:   off = 4'd12;
      default: off = 4'd0;
    endcase
  end

  assign mem_req   = mem_busy;
  assign mem_chan  = mem_own;
  assign mem_we    = (st[mem_own] == S_STS);
  assign mem_addr  = ptr[mem_own] + {{(AW-4){1'b0}}, off};
  assign mem_wdata = sts[mem_own];
  assign mem_acc   = mem_req & mem_ack;

  assign exe_req   = exe_busy;
  assign exe_chan  = exe_own;
  assign exe_cmd   = cmd[exe_own];
  assign exe_fin   = exe_req & exe_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_busy <= 1'b0;
      mem_own  <= '0;
      mem_rr   <= '0;
    end else if (!mem_busy && |mem_want) begin
      mem_busy <= 1'b1;
      mem_own  <= rr_pick(mem_want, mem_rr);
    end else if (mem_acc) begin
      mem_busy <= 1'b0;
      mem_rr   <= rr_next(mem_own);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exe_busy <= 1'b0;
      exe_own  <= '0;
      exe_rr   <= '0;
    end else if (!exe_busy && |exe_want) begin
      exe_busy <= 1'b1;
      exe_own  <= rr_pick(exe_want, exe_rr);
    end else if (exe_fin) begin
      exe_busy <= 1'b0;
      exe_rr   <= rr_next(exe_own);
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        st[c]  <= S_IDLE;
        ptr[c] <= '0;
        nxt[c] <= '0;
        cmd[c] <= '0;
        sts[c] <= '0;
        ien[c] <= 1'b0;
        irq[c] <= 1'b0;
      end else begin
        if (irq_clr[c]) irq[c] <= 1'b0;
        case (st[c])
          S_IDLE:
            if (start_vld[c] && start_ptr[c*AW +: AW] != '0) begin
              ptr[c] <= start_ptr[c*AW +: AW];
              st[c]  <= S_NXT;
            end
          S_NXT:
            if (mem_acc && int'(mem_own) == c) begin
              nxt[c] <= mem_rdata[AW-1:0];
              st[c]  <= S_CMD;
            end
          S_CMD:
            if (mem_acc && int'(mem_own) == c) begin
              cmd[c] <= mem_rdata;
              st[c]  <= S_IEN;
            end
          S_IEN:
            if (mem_acc && int'(mem_own) == c) begin
              ien[c] <= mem_rdata[0];
              st[c]  <= S_EXE;
            end
          S_EXE:
            if (exe_fin && int'(exe_own) == c) begin
              sts[c] <= exe_status | 32'h8000_0000;
              st[c]  <= S_STS;
            end
          default:
            if (mem_acc && int'(mem_own) == c) begin
              if (ien[c]) irq[c] <= 1'b1;
              if (nxt[c] == '0) st[c] <= S_IDLE;
              else begin
                ptr[c] <= nxt[c];
                st[c]  <= S_NXT;
              end
            end
        endcase
      end
    end
  end

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_chan));

  // R9
  exe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exe_req && !exe_done |=> exe_req && $stable(exe_chan) && $stable(exe_cmd));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R10
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[g]) |-> $past(irq_clr[g]));

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[g]) |-> $past(start_vld[g]));

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $past(mem_req && mem_ack && mem_we && int'(mem_chan) == g));
  end
endmodule

// File: tb/sim_desc_chain_engine.sv
module sim_desc_chain_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW  = 32;

  // fields: chan(2) head(10) len(3) ien mask(3) ack lag(2)
  localparam logic [19:0] VEC [5] = '{
    {2'd0, 10'h040, 3'd1, 3'b001, 2'd0},
    {2'd1, 10'h100, 3'd3, 3'b000, 2'd1},
    {2'd2, 10'h200, 3'd2, 3'b010, 2'd2},
    {2'd3, 10'h300, 3'd3, 3'b100, 2'd0},
    {2'd1, 10'h080, 3'd1, 3'b000, 2'd2}
  };

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] start_vld = '0, irq_clr = '0;
  logic [NCH*AW-1:0] start_ptr = '0;
  logic [NCH-1:0] busy, irq;
  logic mem_req, mem_we, mem_ack = 0, exe_req, exe_done = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0, exe_cmd, exe_status = '0;
  logic [1:0] mem_chan, exe_chan;

  desc_chain_engine #(.NCH(NCH), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_ptr(start_ptr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_chan(mem_chan), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .exe_req(exe_req), .exe_cmd(exe_cmd), .exe_chan(exe_chan), .exe_done(exe_done),
    .exe_status(exe_status), .irq_clr(irq_clr), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [256];
  logic [31:0] mlog_addr [64];
  logic        mlog_we   [64];
  logic [1:0]  mlog_ch   [64];
  logic [1:0]  elog_ch   [64];
  logic [31:0] elog_cmd  [64];
  int mcnt = 0, ecnt = 0, mwait = 0, ewait = 0, mem_lag = 0;
  logic hw_en = 0, hw_clr = 0;
  logic [7:0] hw_a = '0;
  logic [31:0] hw_d = '0;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    if (hw_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      mcnt <= 0;
      ecnt <= 0;
    end else if (hw_en) mem[hw_a] <= hw_d;
    if (mem_ack) mem_ack <= 0;
    else if (mem_req) begin
      if (mwait >= mem_lag) begin
        mem_ack   <= 1;
        mwait     <= 0;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (mcnt < 64) begin
          mlog_addr[mcnt] <= mem_addr;
          mlog_we[mcnt]   <= mem_we;
          mlog_ch[mcnt]   <= mem_chan;
          mcnt <= mcnt + 1;
        end
      end else mwait <= mwait + 1;
    end
    if (exe_done) exe_done <= 0;
    else if (exe_req) begin
      if (ewait >= 2) begin
        exe_done   <= 1;
        ewait      <= 0;
        exe_status <= {1'b0, exe_cmd[30:0] ^ 31'h0055_AA00};
        if (ecnt < 64) begin
          elog_ch[ecnt]  <= exe_chan;
          elog_cmd[ecnt] <= exe_cmd;
          ecnt <= ecnt + 1;
        end
      end else ewait <= ewait + 1;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk); hw_a = a[9:2]; hw_d = d; hw_en = 1;
    @(posedge clk); hw_en = 0;
  endtask

  task automatic wipe();
    @(posedge clk); hw_clr = 1;
    @(posedge clk); hw_clr = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic start_ch(input int c, input logic [31:0] head);
    @(negedge clk);
    start_vld[c] = 1;
    start_ptr[c*AW +: AW] = head;
    @(negedge clk);
    start_vld = '0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (busy != '0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  function automatic logic [31:0] cmd_of(input logic [31:0] base, input int k);
    return 32'h4000_0000 | (base << 8) | k;
  endfunction

  function automatic logic [31:0] sts_of(input logic [31:0] c);
    return {1'b1, c[30:0] ^ 31'h0055_AA00};
  endfunction

  task automatic build(input logic [31:0] head, input int len, input logic [2:0] mask);
    for (int k = 0; k < len; k++) begin
      logic [31:0] a;
      a = head + 16 * k;
      poke(a, (k == len - 1) ? 32'h0 : a + 16);
      poke(a + 4, cmd_of(head, k));
      poke(a + 8, {31'b0, mask[k]});
      poke(a + 12, 32'h0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk(busy == 0 && irq == 0, "R1 busy/irq", {busy, irq}, 0);
    chk(!mem_req && !exe_req, "R1 req", {mem_req, exe_req}, 0);
    wipe();

    for (int v = 0; v < 5; v++) begin
      int c, len;
      logic [31:0] head;
      logic [2:0] mask;
      bit exp_irq;
      c = int'(VEC[v][19:18]);
      head = {22'b0, VEC[v][17:8]};
      len = int'(VEC[v][7:5]);
      mask = VEC[v][4:2];
      mem_lag = int'(VEC[v][1:0]);
      exp_irq = 0;
      wipe();
      build(head, len, mask);
      start_ch(c, head);
      chk(busy[c], "R2 busy after start", {31'b0, busy[c]}, 1);
      wait_idle();
      // R2 fetch order and R4 status write location
      chk(mcnt >= 4 && mlog_addr[0] == head && !mlog_we[0] && mlog_addr[1] == head + 4 &&
          !mlog_we[1] && mlog_addr[2] == head + 8 && !mlog_we[2],
          "R2 fetch order", mlog_addr[2], head + 8);
      chk(mlog_addr[3] == head + 12 && mlog_we[3], "R4 write addr", mlog_addr[3], head + 12);
      // R3 command and channel given to the executor
      chk(elog_cmd[0] == cmd_of(head, 0) && int'(elog_ch[0]) == c, "R3 exe cmd", elog_cmd[0], cmd_of(head, 0));
      // R6 every descriptor of the chain was followed
      chk(ecnt == len && mcnt == 4 * len, "R6 chain length", ecnt, len);
      for (int k = 0; k < len; k++) begin
        chk(mem[(head[9:2]) + 4 * k + 3] == sts_of(cmd_of(head, k)), "R4 status word",
            mem[(head[9:2]) + 4 * k + 3], sts_of(cmd_of(head, k)));
        if (mask[k]) exp_irq = 1;
      end
      chk(irq[c] == exp_irq, "R5 irq", {31'b0, irq[c]}, {31'b0, exp_irq});
      repeat (4) @(negedge clk);
      chk(irq[c] == exp_irq, "R10 irq sticky", {31'b0, irq[c]}, {31'b0, exp_irq});
      irq_clr = '1;
      @(negedge clk);
      irq_clr = '0;
      @(negedge clk);
      chk(irq == '0, "R10 irq cleared", {28'b0, irq}, 0);
    end

    // R7 a restart while busy is ignored, a zero head is ignored
    do_reset();
    wipe();
    mem_lag = 2;
    build(32'h040, 3, 3'b000);
    build(32'h380, 1, 3'b001);
    start_ch(0, 32'h040);
    repeat (4) @(negedge clk);
    start_ch(0, 32'h380);
    wait_idle();
    chk(mem[8'hE3] == 32'h0, "R7 restart ignored", mem[8'hE3], 0);
    chk(ecnt == 3 && irq[0] == 0, "R7 chain unaffected", ecnt, 3);
    start_ch(2, 32'h0);
    chk(busy[2] == 0 && mem_req == 0, "R7 zero head", {31'b0, busy[2]}, 0);

    // R8 R9 all four channels start in one cycle
    do_reset();
    wipe();
    mem_lag = 0;
    for (int c = 0; c < NCH; c++) build(32'h040 + 32'h40 * c, 1, 3'b001);
    @(negedge clk);
    start_vld = '1;
    for (int c = 0; c < NCH; c++) start_ptr[c*AW +: AW] = 32'h040 + 32'h40 * c;
    @(negedge clk);
    start_vld = '0;
    wait_idle();
    for (int c = 0; c < NCH; c++) begin
      chk(int'(mlog_ch[c]) == c, "R8 memory rotation", {30'b0, mlog_ch[c]}, c);
      chk(int'(elog_ch[c]) == c, "R9 executor rotation", {30'b0, elog_ch[c]}, c);
      chk(mem[(8'h10 + 8'h10 * c) + 3] == sts_of(cmd_of(32'h040 + 32'h40 * c, 0)), "R4 concurrent status",
          mem[(8'h10 + 8'h10 * c) + 3], sts_of(cmd_of(32'h040 + 32'h40 * c, 0)));
    end
    chk(irq == '1, "R5 all irq", {28'b0, irq}, 32'hF);

    finish_run();
  end
endmodule